// File: doc/BRIEF.md
# Inhibit Pulse Classifier and Sample Scheduler

This block watches one logic input that serves two purposes in a battery charger. Short high strobes on it are synchronization marks: each one asks for a battery-voltage sample on its falling edge. A long high level on the same input means the charge is inhibited. When that happens the stored voltage history must be discarded. The block tells these cases apart by measuring how long the input stays high, counted in ticks of a prescaled clock. It then issues a one-cycle sample trigger, an inhibit level and a one-cycle history-clear pulse to the detector and the charge controller.

When no strobes arrive, the block falls back to free-running samples at a fixed cadence. After a valid strobe it enters a locked state. In that state a watchdog allows up to a rate-dependent maximum period for the next strobe. If the period expires, the block issues a sample itself and returns to free-running. Every trigger, of either kind, restarts the watchdog.

Top module: `inhibit_sync_sched`

## Requirements
- R1: A high pulse whose measured width W satisfies STROBE_MIN_TICKS <= W <= STROBE_MAX_TICKS is a strobe. It produces exactly one one-cycle `sample_fire_o` pulse on the third rising clock edge after the first edge that samples the input low. The input passes through two synchronizer flops.
- R2: A high pulse shorter than STROBE_MIN_TICKS produces no sample.
- R3: A high pulse longer than STROBE_MAX_TICKS but shorter than INHIBIT_TICKS produces no sample and no inhibit, and it never pulses `hist_clear_o`.
- R4: When the input has been high for INHIBIT_TICKS, `hist_clear_o` pulses once and `inhibit_o` goes high. `inhibit_o` stays high until the cycle after the synchronized input falls, and the release produces no sample.
- R5: During reset all three outputs are low, and the scheduler starts in free-run mode with its period counter at zero.
- R6: In free-run mode with no strobes, `sample_fire_o` pulses every FREE_RUN_TICKS ticks. The first pulse comes FREE_RUN_TICKS ticks after reset is released.
- R7: After a strobe the scheduler is locked. If no further strobe arrives, a sample fires SYNC_SLOW_TICKS ticks later when `rate_fast_i`=0, or SYNC_FAST_TICKS ticks later when `rate_fast_i`=1. That expiry returns the scheduler to free-run mode.
- R8: Every trigger, whether a strobe or an expiry, restarts the period count from zero.
- R9: When a strobe and a watchdog expiry fall in the same cycle, only one sample pulse is issued and the scheduler ends up locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inh_pin_i | input | 1 | Asynchronous strobe/inhibit input, active high |
| rate_fast_i | input | 1 | 1 selects the short locked period (2C rate), 0 the long one |
| sample_fire_o | output | 1 | One-cycle voltage-sample trigger |
| inhibit_o | output | 1 | Charge inhibit level |
| hist_clear_o | output | 1 | One-cycle sample-history erase |

## Verification
The assertions assume that `rate_fast_i` changes only at a trigger or while the scheduler is idle in free-run mode. They also assume that every period and width parameter is at least 2, so triggers can never land on consecutive cycles. The stimulus drives the input and the rate select half a clock away from the active edge. It changes the rate only right after an observed sample, and it spaces strobes at least a few cycles apart so that each falling edge is seen on its own. The bench uses a one-clock tick so that widths and periods line up with cycle counts. One strobe is deliberately timed to fall in the same cycle as a watchdog expiry.

// File: rtl/inhibit_sync_pkg.sv
`timescale 1ns/1ps
package inhibit_sync_pkg;

  typedef enum logic {
    SCHED_FREE   = 1'b0,
    SCHED_LOCKED = 1'b1
  } sched_mode_e;

  // A measured high width counts as a sync strobe inside the closed window.
  function automatic logic width_is_strobe(input int unsigned width,
                                           input int unsigned lo,
                                           input int unsigned hi);
    return (width >= lo) && (width <= hi);
  endfunction

  // Period the watchdog allows before it issues a trigger itself.
  function automatic int unsigned pick_limit(input logic        locked,
                                             input logic        fast,
                                             input int unsigned free_t,
                                             input int unsigned slow_t,
                                             input int unsigned fast_t);
    if (!locked) return free_t;
    return fast ? fast_t : slow_t;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/strobe_tick_gen.sv
`timescale 1ns/1ps
module strobe_tick_gen #(
  parameter int unsigned TICK_DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0] div_q;

  assign tick_o = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/strobe_width_sorter.sv
`timescale 1ns/1ps
module strobe_width_sorter
  import inhibit_sync_pkg::*;
#(
  parameter int unsigned STROBE_MIN_TICKS = 1,
  parameter int unsigned STROBE_MAX_TICKS = 35000,
  parameter int unsigned INHIBIT_TICKS    = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic tick_i,
  output logic strobe_o,
  output logic inhibit_o,
  output logic hist_clear_o
);
  localparam int unsigned HW = $clog2(INHIBIT_TICKS + 1);

  logic          meta_q, lvl_q, prev_q;
  logic [HW-1:0] high_q;
  logic          fall_w, at_cap_w, cap_hit_w;
  logic          inh_q, clr_q;

  // Two-flop synchronizer plus one delay stage for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign fall_w    = prev_q & ~lvl_q;
  assign at_cap_w  = (high_q == HW'(INHIBIT_TICKS));
  assign cap_hit_w = lvl_q && tick_i && (high_q == HW'(INHIBIT_TICKS - 1));
  assign strobe_o  = fall_w &&
                     width_is_strobe(32'(high_q), STROBE_MIN_TICKS, STROBE_MAX_TICKS);

  // High-width counter in ticks, saturating at the inhibit threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   high_q <= '0;
    else if (!lvl_q)              high_q <= '0;
    else if (tick_i && !at_cap_w) high_q <= high_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= cap_hit_w;
      inh_q <= lvl_q && (at_cap_w || cap_hit_w);
    end
  end

  assign inhibit_o    = inh_q;
  assign hist_clear_o = clr_q;
endmodule

// File: rtl/sample_watchdog.sv
`timescale 1ns/1ps
module sample_watchdog
  import inhibit_sync_pkg::*;
#(
  parameter int unsigned FREE_RUN_TICKS  = 170000000,
  parameter int unsigned SYNC_SLOW_TICKS = 187000000,
  parameter int unsigned SYNC_FAST_TICKS = 94000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic strobe_i,
  input  logic fast_i,
  output logic fire_o,
  output logic expire_o,
  output logic locked_o
);
  localparam int unsigned MAX_LIM = max3(FREE_RUN_TICKS, SYNC_SLOW_TICKS, SYNC_FAST_TICKS);
  localparam int unsigned WW      = $clog2(MAX_LIM + 1);

  sched_mode_e   mode_q;
  logic [WW-1:0] wd_q;
  int unsigned   limit_w;
  logic          trig_w;
  logic          fire_q;

  always_comb begin
    limit_w  = pick_limit(mode_q == SCHED_LOCKED, fast_i,
                          FREE_RUN_TICKS, SYNC_SLOW_TICKS, SYNC_FAST_TICKS);
    expire_o = tick_i && (wd_q >= WW'(limit_w - 1));
    trig_w   = strobe_i || expire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q   <= '0;
      mode_q <= SCHED_FREE;
      fire_q <= 1'b0;
    end else begin
      fire_q <= trig_w;
      if (trig_w)      wd_q <= '0;
      else if (tick_i) wd_q <= wd_q + 1'b1;
      if (strobe_i)      mode_q <= SCHED_LOCKED;
      else if (expire_o) mode_q <= SCHED_FREE;
    end
  end

  assign fire_o   = fire_q;
  assign locked_o = (mode_q == SCHED_LOCKED);
endmodule

// File: rtl/inhibit_sync_sched.sv
`timescale 1ns/1ps
module inhibit_sync_sched #(
  parameter int unsigned TICK_DIV         = 5,
  parameter int unsigned STROBE_MIN_TICKS = 1,
  parameter int unsigned STROBE_MAX_TICKS = 35000,
  parameter int unsigned INHIBIT_TICKS    = 120000,
  parameter int unsigned FREE_RUN_TICKS   = 170000000,
  parameter int unsigned SYNC_SLOW_TICKS  = 187000000,
  parameter int unsigned SYNC_FAST_TICKS  = 94000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inh_pin_i,
  input  logic rate_fast_i,
  output logic sample_fire_o,
  output logic inhibit_o,
  output logic hist_clear_o
);
  // Internal events brought out by name for the checker.
  logic tick_w;
  logic strobe_w;
  logic expire_w;
  logic locked_w;

  strobe_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  strobe_width_sorter #(
    .STROBE_MIN_TICKS (STROBE_MIN_TICKS),
    .STROBE_MAX_TICKS (STROBE_MAX_TICKS),
    .INHIBIT_TICKS    (INHIBIT_TICKS)
  ) u_sorter (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_i        (inh_pin_i),
    .tick_i       (tick_w),
    .strobe_o     (strobe_w),
    .inhibit_o    (inhibit_o),
    .hist_clear_o (hist_clear_o)
  );

  sample_watchdog #(
    .FREE_RUN_TICKS  (FREE_RUN_TICKS),
    .SYNC_SLOW_TICKS (SYNC_SLOW_TICKS),
    .SYNC_FAST_TICKS (SYNC_FAST_TICKS)
  ) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_w),
    .strobe_i (strobe_w),
    .fast_i   (rate_fast_i),
    .fire_o   (sample_fire_o),
    .expire_o (expire_w),
    .locked_o (locked_w)
  );
endmodule

// File: rtl/inhibit_sync_sched_chk.sv
`timescale 1ns/1ps
module inhibit_sync_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_fire_o,
  input logic inhibit_o,
  input logic hist_clear_o,
  input logic strobe_w,
  input logic expire_w,
  input logic locked_w
);
  // R1
  strobe_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_w |=> sample_fire_o);

  // R1
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_fire_o |=> !sample_fire_o);

  // R4
  clear_in_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clear_o |-> inhibit_o);

  // R4
  inhibit_rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit_o) |-> hist_clear_o);

  // R4
  clear_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clear_o |=> !hist_clear_o);

  // R7
  expiry_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !strobe_w) |=> !locked_w);

  // R9
  strobe_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_w |=> locked_w);
endmodule

bind inhibit_sync_sched inhibit_sync_sched_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sample_fire_o (sample_fire_o),
  .inhibit_o     (inhibit_o),
  .hist_clear_o  (hist_clear_o),
  .strobe_w      (strobe_w),
  .expire_w      (expire_w),
  .locked_w      (locked_w)
);

// File: tb/inhibit_sync_sched_test.sv
`timescale 1ns/1ps
module inhibit_sync_sched_test;
  localparam int P_MIN  = 3;
  localparam int P_MAX  = 20;
  localparam int P_INH  = 40;
  localparam int P_FREE = 170;
  localparam int P_SLOW = 187;
  localparam int P_FAST = 94;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic fast = 1'b0;
  logic fire, inh, clr;

  inhibit_sync_sched #(
    .TICK_DIV(1), .STROBE_MIN_TICKS(P_MIN), .STROBE_MAX_TICKS(P_MAX),
    .INHIBIT_TICKS(P_INH), .FREE_RUN_TICKS(P_FREE),
    .SYNC_SLOW_TICKS(P_SLOW), .SYNC_FAST_TICKS(P_FAST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .inh_pin_i(pin), .rate_fast_i(fast),
    .sample_fire_o(fire), .inhibit_o(inh), .hist_clear_o(clr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int clr_cnt = 0;
  bit inh_seen = 0;
  bit done = 0;
  int fire_at[$];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: the input delayed through a queue, a width count,
  // a ticks-since-trigger count and a locked flag.
  bit pipe_q[$] = '{0, 0, 0};
  int m_high = 0, m_since = 0;
  bit m_locked = 0, e_fire = 0, e_inh = 0, e_clr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe_q = '{0, 0, 0};
      m_high = 0; m_since = 0; m_locked = 0;
      e_fire = 0; e_inh = 0; e_clr = 0;
    end else begin
      bit now_hi, was_hi, strobe, expire;
      int lim;
      now_hi = pipe_q[1];
      was_hi = pipe_q[2];
      strobe = was_hi && !now_hi && m_high >= P_MIN && m_high <= P_MAX;
      lim    = !m_locked ? P_FREE : (fast ? P_FAST : P_SLOW);
      expire = (m_since + 1 >= lim);
      e_fire = strobe || expire;
      e_clr  = now_hi && (m_high + 1 == P_INH);
      e_inh  = now_hi && (m_high + 1 >= P_INH);
      m_high = now_hi ? ((m_high < P_INH) ? m_high + 1 : m_high) : 0;
      m_since = e_fire ? 0 : m_since + 1;
      if (strobe) m_locked = 1;
      else if (expire) m_locked = 0;
      pipe_q.push_front(pin);
      void'(pipe_q.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(fire == e_fire, "R1", "model sample_fire", fire, e_fire);
      chk(inh == e_inh, "R4", "model inhibit", inh, e_inh);
      chk(clr == e_clr, "R4", "model hist_clear", clr, e_clr);
      if (fire) fire_at.push_back(cyc);
      if (clr) clr_cnt++;
      if (inh) inh_seen = 1;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(input int w, output int rel);
    pin = 1'b1;
    repeat (w) step();
    pin = 1'b0;
    rel = cyc;
  endtask

  task automatic wait_fires(input int n);
    while (fire_at.size() < n) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    int rel, n, f0;
    repeat (4) step();
    // R5 reset state
    chk(fire == 0 && inh == 0 && clr == 0, "R5", "outputs in reset",
        {fire, inh, clr}, 0);
    rst_n = 1'b1;

    // R6 free-run cadence
    wait_fires(2);
    chk(fire_at[0] == P_FREE, "R6", "first free sample", fire_at[0], P_FREE);
    chk(fire_at[1] - fire_at[0] == P_FREE, "R6", "free period",
        fire_at[1] - fire_at[0], P_FREE);

    // R1 strobe timing and width boundaries
    n = fire_at.size();
    pulse(5, rel); repeat (4) step();
    chk(fire_at.size() == n + 1, "R1", "strobe sample count", fire_at.size() - n, 1);
    chk(fire_at[$] == rel + 3, "R1", "strobe sample cycle", fire_at[$], rel + 3);
    n = fire_at.size();
    pulse(2, rel); repeat (6) step();
    chk(fire_at.size() == n, "R2", "short pulse ignored", fire_at.size() - n, 0);
    pulse(P_MAX, rel); repeat (4) step();
    chk(fire_at.size() == n + 1, "R1", "max width strobe", fire_at.size() - n, 1);
    pulse(P_MIN, rel); repeat (4) step();
    chk(fire_at.size() == n + 2, "R1", "min width strobe", fire_at.size() - n, 2);

    // R3 middle band ignored
    n = fire_at.size(); inh_seen = 0; clr_cnt = 0;
    pulse(P_MAX + 1, rel); repeat (6) step();
    pulse(P_INH - 1, rel); repeat (6) step();
    chk(fire_at.size() == n, "R3", "middle band samples", fire_at.size() - n, 0);
    chk(!inh_seen && clr_cnt == 0, "R3", "middle band inhibit/clear",
        inh_seen + clr_cnt, 0);

    // R4 long high: inhibit and history clear
    pulse(5, rel); repeat (4) step();
    clr_cnt = 0;
    pin = 1'b1; repeat (60) step();
    chk(inh == 1, "R4", "inhibit held", inh, 1);
    chk(clr_cnt == 1, "R4", "single history clear", clr_cnt, 1);
    n = fire_at.size();
    pin = 1'b0; repeat (6) step();
    chk(inh == 0, "R4", "inhibit released", inh, 0);
    chk(fire_at.size() == n, "R4", "no sample on release", fire_at.size() - n, 0);

    // R7 locked slow period then fallback to free-run
    pulse(5, rel); wait_fires(n + 1);
    f0 = fire_at[$];
    wait_fires(n + 3);
    chk(fire_at[n + 1] - f0 == P_SLOW, "R7", "slow locked expiry",
        fire_at[n + 1] - f0, P_SLOW);
    chk(fire_at[n + 2] - fire_at[n + 1] == P_FREE, "R7", "fallback free period",
        fire_at[n + 2] - fire_at[n + 1], P_FREE);

    // R7 locked fast period
    fast = 1'b1;
    n = fire_at.size();
    pulse(5, rel); wait_fires(n + 2);
    chk(fire_at[n + 1] - fire_at[n] == P_FAST, "R7", "fast locked expiry",
        fire_at[n + 1] - fire_at[n], P_FAST);
    fast = 1'b0;

    // R8 a second strobe restarts the count
    n = fire_at.size();
    pulse(5, rel); wait_fires(n + 1);
    repeat (50) step();
    pulse(5, rel); wait_fires(n + 3);
    chk(fire_at[n + 2] - fire_at[n + 1] == P_SLOW, "R8", "restart on strobe",
        fire_at[n + 2] - fire_at[n + 1], P_SLOW);

    // R9 strobe coinciding with expiry
    n = fire_at.size();
    pulse(5, rel); wait_fires(n + 1);
    f0 = fire_at[$];
    repeat (P_SLOW - 8) step();
    pulse(5, rel);
    wait_fires(n + 3);
    chk(fire_at[n + 1] == f0 + P_SLOW, "R9", "single coincident sample",
        fire_at[n + 1], f0 + P_SLOW);
    chk(fire_at[n + 2] == f0 + 2 * P_SLOW, "R9", "still locked after coincidence",
        fire_at[n + 2], f0 + 2 * P_SLOW);

    repeat (5) step();
    finish_run();
  end
endmodule